// File: doc/BRIEF.md
# Serial ADC Lane Word Aligner

This block takes one serialized ADC data lane, the matching bit clock and the frame clock, and turns them into 12-bit parallel sample words. The lane carries two bits per bit-clock period: one is captured on the rising edge and one on the falling edge. Both are shifted into a history register, most significant bit first. On each rising edge of the frame clock, a 12-bit window is taken out of that history. The window's position is set by a slip count.

The data lane and the frame clock can arrive with an unknown skew between them. To remove it, the ADC is put into a test mode in which every word has only its top bit set. With the calibration input held high, the block checks the captured word once per frame. Each time the word is not exactly 0x800, it moves the word boundary by one bit. Once the pattern reads correctly on enough consecutive frames, it raises a lock flag and freezes the slip count. If none of the twelve boundary positions works, it raises an error flag and stops.

After lock, the calibration input is lowered. From then on the block emits one aligned sample per frame, together with a one-cycle valid strobe.

Top module: `adc_lane_aligner`

## Requirements
- R1: Serial bits are taken on both bit-clock edges, the rising-edge bit being the earlier one, and are assembled most significant bit first. Each rising edge of the frame clock yields one 12-bit word.
- R2: When the block is locked and `calib_mode` is low, it produces exactly one word per frame on `sample_o`. Each word has a one-cycle `sample_valid_o` pulse, and the words follow the transmitted samples in order.
- R3: `sample_valid_o` is never high unless the block is locked and `calib_mode` was low. It therefore stays low throughout calibration and after an error.
- R4: The search only advances on frames in which `calib_mode` is high. After reset, and after every slip, the block ignores 2 frames before it checks a word again. Each failing check raises `slip_o` by exactly one.
- R5: Lock is declared once the captured word equals 0x800 on 4 consecutive checks. A slip value k takes the word k bits earlier in the stream. So a lane that lags the nominal frame boundary by d bits (0..11) locks with `slip_o` = (12 - d) mod 12.
- R6: Once locked, `locked_o` stays high and `slip_o` stays fixed until reset, whatever pattern arrives and whatever the level of `calib_mode`.
- R7: If a check fails while `slip_o` is 11, `align_err_o` rises and stays high. In that state `slip_o` stays at 11, `locked_o` stays low and no further search happens until reset. This holds for an all-zero pattern and for a pattern with two ones.
- R8: A synchronous active-high `rst` clears `slip_o`, `locked_o`, `align_err_o` and `sample_valid_o`, and restarts calibration.
- R9: While the block is not locked and `calib_mode` is low, `slip_o` does not move and lock is never declared.
- R10: Lock cannot be declared in fewer than 2 + 4 frames after reset. With a lane that is already aligned, lock is reached within 8 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data is sampled on both of its edges |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serialized ADC data lane, two bits per clock period |
| frame_clk | input | 1 | Frame clock; its rising edge marks a word boundary |
| calib_mode | input | 1 | High while the ADC is sending the MSB-only test pattern |
| sample_o | output | 12 | Aligned parallel sample word |
| sample_valid_o | output | 1 | One-cycle strobe per aligned word in normal mode |
| slip_o | output | 4 | Current word-boundary slip count, 0..11 |
| locked_o | output | 1 | Alignment found and frozen |
| align_err_o | output | 1 | No boundary position matched the test pattern |

## Verification
The MSB-only pattern is sent at each of the twelve possible lane-to-frame skews. The resulting slip count is compared with (12 - d) mod 12, which confirms both the direction of the slip and the wrap-around.

After each lock, a stream of distinct, bijectively coded samples is sent. Any misaligned or reordered word breaks the expected sequence.

An all-zero pattern and a pattern with two ones separate a correct lone-bit search from a search that accepts any nonzero word. Both must end in the error state at slip 11. Sending garbage after lock, and holding calibration low before lock, show that the slip count is frozen in the first case and idle in the second.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

    // Word geometry
    localparam int unsigned WORD_W = 12;
    localparam int unsigned SLIP_W = $clog2(WORD_W);
    localparam int unsigned HIST_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLIP_W-1:0] slip_t;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_CHECK,
        ST_LOCKED,
        ST_FAILED
    } align_state_e;

    typedef struct packed {
        logic  tick;
        word_t data;
    } frame_word_t;

    function automatic logic lone_msb(input word_t w);
        return w == (word_t'(1) << (WORD_W - 1));
    endfunction

endpackage

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture
    import adc_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_din,
    output logic [HIST_W-1:0] hist_o
);

    logic rise_q;
    logic fall_q;

    // Falling-edge half of the double-rate capture
    always_ff @(negedge clk) begin
        fall_q <= ser_din;
    end

    // Rising-edge half; each period pushes the earlier (rise) then later (fall) bit
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= 1'b0;
            hist_o <= '0;
        end else begin
            rise_q <= ser_din;
            hist_o <= {hist_o[HIST_W-3:0], rise_q, fall_q};
        end
    end

endmodule

// File: rtl/adc_frame_detect.sv
module adc_frame_detect (
    input  logic clk,
    input  logic rst,
    input  logic frame_clk,
    output logic edge_o
);

    logic fr_d1;
    logic fr_d2;

    // Reset both stages high so no false rising edge follows reset release
    always_ff @(posedge clk) begin
        if (rst) begin
            fr_d1 <= 1'b1;
            fr_d2 <= 1'b1;
        end else begin
            fr_d1 <= frame_clk;
            fr_d2 <= fr_d1;
        end
    end

    assign edge_o = fr_d1 & ~fr_d2;

endmodule

// File: rtl/adc_word_extract.sv
module adc_word_extract
    import adc_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] hist_i,
    input  slip_t             slip_i,
    input  logic              edge_i,
    output frame_word_t       fw_o
);

    word_t window;

    // Larger slip selects older bits, moving the boundary earlier in the stream
    always_comb begin
        window = word_t'(hist_i >> slip_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fw_o <= '0;
        end else begin
            fw_o.tick <= edge_i;
            if (edge_i) begin
                fw_o.data <= window;
            end
        end
    end

endmodule

// File: rtl/adc_align_ctrl.sv
module adc_align_ctrl
    import adc_align_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES   = 4,
    parameter int unsigned SETTLE_FRAMES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         calib_i,
    input  frame_word_t  fw_i,
    output slip_t        slip_o,
    output align_state_e state_o
);

    localparam int unsigned SET_W  = (SETTLE_FRAMES > 1) ? $clog2(SETTLE_FRAMES) : 1;
    localparam int unsigned GOOD_W = (LOCK_FRAMES > 1) ? $clog2(LOCK_FRAMES) : 1;

    logic [SET_W-1:0]  settle_cnt;
    logic [GOOD_W-1:0] good_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o    <= ST_SETTLE;
            slip_o     <= '0;
            settle_cnt <= '0;
            good_cnt   <= '0;
        end else if (fw_i.tick && calib_i) begin
            unique case (state_o)
                ST_SETTLE: begin
                    if (settle_cnt == SET_W'(SETTLE_FRAMES - 1)) begin
                        settle_cnt <= '0;
                        good_cnt   <= '0;
                        state_o    <= ST_CHECK;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (lone_msb(fw_i.data)) begin
                        if (good_cnt == GOOD_W'(LOCK_FRAMES - 1)) begin
                            state_o <= ST_LOCKED;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end else begin
                        good_cnt <= '0;
                        if (slip_o == slip_t'(WORD_W - 1)) begin
                            state_o <= ST_FAILED;
                        end else begin
                            slip_o  <= slip_o + 1'b1;
                            state_o <= ST_SETTLE;
                        end
                    end
                end
                default: begin
                    // locked or failed: hold everything
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_lane_aligner.sv
module adc_lane_aligner
    import adc_align_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES   = 4,
    parameter int unsigned SETTLE_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_din,
    input  logic              frame_clk,
    input  logic              calib_mode,
    output logic [WORD_W-1:0] sample_o,
    output logic              sample_valid_o,
    output logic [SLIP_W-1:0] slip_o,
    output logic              locked_o,
    output logic              align_err_o
);

    logic [HIST_W-1:0] hist;
    logic              fr_edge;
    frame_word_t       fw;
    align_state_e      state;
    slip_t             slip;

    adc_ddr_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .ser_din (ser_din),
        .hist_o  (hist)
    );

    adc_frame_detect u_frm (
        .clk       (clk),
        .rst       (rst),
        .frame_clk (frame_clk),
        .edge_o    (fr_edge)
    );

    adc_word_extract u_ext (
        .clk    (clk),
        .rst    (rst),
        .hist_i (hist),
        .slip_i (slip),
        .edge_i (fr_edge),
        .fw_o   (fw)
    );

    adc_align_ctrl #(
        .LOCK_FRAMES   (LOCK_FRAMES),
        .SETTLE_FRAMES (SETTLE_FRAMES)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .calib_i (calib_mode),
        .fw_i    (fw),
        .slip_o  (slip),
        .state_o (state)
    );

    // Output stage: one registered word per frame once aligned, normal mode only
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o       <= '0;
            sample_valid_o <= 1'b0;
        end else begin
            sample_valid_o <= fw.tick && (state == ST_LOCKED) && !calib_mode;
            if (fw.tick && (state == ST_LOCKED) && !calib_mode) begin
                sample_o <= fw.data;
            end
        end
    end

    assign slip_o      = slip;
    assign locked_o    = (state == ST_LOCKED);
    assign align_err_o = (state == ST_FAILED);

endmodule

// File: rtl/adc_lane_aligner_chk.sv
module adc_lane_aligner_chk
    import adc_align_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              calib_mode,
    input logic              sample_valid_o,
    input logic [SLIP_W-1:0] slip_o,
    input logic              locked_o,
    input logic              align_err_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (slip_o == '0) && !locked_o && !align_err_o && !sample_valid_o); // R8

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |-> locked_o); // R3

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |=> !sample_valid_o); // R2

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && locked_o) |=> locked_o && $stable(slip_o)); // R6

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && align_err_o) |=> align_err_o && !locked_o && $stable(slip_o)); // R7

    AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(locked_o && align_err_o)); // R5

    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (slip_o != $past(slip_o))) |-> (slip_o == $past(slip_o) + 1'b1)); // R4

    AST_IDLE_NO_SLIP: assert property (@(posedge clk) disable iff (rst)
        (!rst && !calib_mode && !locked_o) |=> $stable(slip_o) && !locked_o); // R9

    AST_SLIP_RANGE: assert property (@(posedge clk) disable iff (rst)
        slip_o <= SLIP_W'(WORD_W - 1)); // R7

endmodule

bind adc_lane_aligner adc_lane_aligner_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .calib_mode     (calib_mode),
    .sample_valid_o (sample_valid_o),
    .slip_o         (slip_o),
    .locked_o       (locked_o),
    .align_err_o    (align_err_o)
);

// File: tb/adc_lane_aligner_bench.sv
module adc_lane_aligner_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_din = 1'b0;
    logic        frame_clk = 1'b1;
    logic        calib_mode = 1'b1;
    logic [11:0] sample_o;
    logic        sample_valid_o;
    logic [3:0]  slip_o;
    logic        locked_o;
    logic        align_err_o;

    int nchk = 0;
    int nerr = 0;
    int slot = 1;
    int delay = 0;
    int pat = 0;           // 0 MSB-only, 1 data, 2 zeros, 3 two ones
    int cal_hold = 0;
    int cal_valid = 0;
    bit done = 0;

    adc_lane_aligner u_adc_lane_aligner (
        .clk            (clk),
        .rst            (rst),
        .ser_din        (ser_din),
        .frame_clk      (frame_clk),
        .calib_mode     (calib_mode),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o),
        .slip_o         (slip_o),
        .locked_o       (locked_o),
        .align_err_o    (align_err_o)
    );

    always #4 clk = ~clk;

    function automatic logic [11:0] samp(input int s);
        return 12'(s * 2531 + 90);
    endfunction

    function automatic logic bitval(input int sl);
        int t;
        int s;
        int pos;
        logic [11:0] w;
        t   = sl + 12 * 4096 - delay;
        s   = t / 12;
        pos = 11 - (t % 12);
        case (pat)
            0:       w = 12'h800;
            1:       w = samp(s);
            2:       w = 12'h000;
            default: w = 12'h820;
        endcase
        return w[pos];
    endfunction

    // Stream driver: slot 2k is sampled at rising edge k, slot 2k+1 at the falling edge after
    initial ser_din = bitval(0);
    always @(posedge clk or negedge clk) begin
        #2;
        ser_din = bitval(slot);
        if (slot % 2 == 0) frame_clk = ((slot / 2) % 6) < 3;
        slot++;
    end

    // Watch for valid strobes during established calibration
    always @(negedge clk) begin
        if (calib_mode) cal_hold++; else cal_hold = 0;
        if (cal_hold >= 2 && sample_valid_o) cal_valid++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frames(input int n);
        repeat (n * 6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_lock(input int max_frames);
        for (int i = 0; i < max_frames * 6; i++) begin
            @(negedge clk);
            if (locked_o || align_err_o) break;
        end
    endtask

    // R1 R2: collect n valid words and require consecutive transmitted samples
    task automatic check_stream(input string req, input int n);
        int got = 0;
        int s0 = -1;
        for (int i = 0; i < n * 18 && got < n; i++) begin
            @(negedge clk);
            if (sample_valid_o) begin
                if (got == 0) begin
                    for (int s = 0; s < 4096; s++)
                        if (samp(s) == sample_o) s0 = s;
                end else begin
                    chk(sample_o == samp(s0 + got), req, int'(sample_o), int'(samp(s0 + got)));
                end
                got++;
            end
        end
        chk(got == n, req, got, n);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int v;
        // R8: state during reset
        repeat (4) @(negedge clk);
        chk(slip_o == 0 && !locked_o && !align_err_o && !sample_valid_o, "R8 reset state",
            {slip_o, locked_o, align_err_o, sample_valid_o}, 0);

        // R10: aligned lane, lock timing
        delay = 0; pat = 0; calib_mode = 1'b1;
        rst = 1'b0;
        frames(4);
        chk(!locked_o, "R10 no early lock", int'(locked_o), 0);
        frames(4);
        chk(locked_o, "R10 lock by 8 frames", int'(locked_o), 1);
        chk(slip_o == 0, "R10 slip aligned", int'(slip_o), 0);

        // R5 R1 R2: sweep every skew
        for (int d = 0; d < 12; d++) begin
            delay = d; pat = 0; calib_mode = 1'b1;
            do_reset();
            wait_lock(80);
            chk(locked_o && !align_err_o, "R5 lock", {locked_o, align_err_o}, 2);
            chk(slip_o == (12 - d) % 12, "R5 slip value", int'(slip_o), (12 - d) % 12);
            pat = 1;
            frames(2);
            calib_mode = 1'b0;
            check_stream("R1 R2 data words", 6);
        end
        chk(cal_valid == 0, "R3 no valid in calibration", cal_valid, 0);

        // R6: lock frozen against garbage and calibration level
        calib_mode = 1'b1; pat = 2;
        frames(10);
        chk(locked_o && slip_o == 1, "R6 frozen zeros", int'(slip_o), 1);
        pat = 3;
        frames(5);
        chk(locked_o && slip_o == 1, "R6 frozen two ones", int'(slip_o), 1);
        pat = 1;
        frames(2);
        calib_mode = 1'b0;
        check_stream("R6 data after garbage", 4);

        // R7: all-zero pattern exhausts search
        delay = 4; pat = 2; calib_mode = 1'b1;
        do_reset();
        frames(60);
        chk(align_err_o && !locked_o, "R7 error zeros", {align_err_o, locked_o}, 2);
        chk(slip_o == 11, "R7 slip at last", int'(slip_o), 11);
        pat = 0;
        frames(20);
        chk(align_err_o && !locked_o && slip_o == 11, "R7 stays failed", int'(slip_o), 11);
        // R3: no output after error
        pat = 1; calib_mode = 1'b0;
        v = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sample_valid_o) v++;
        end
        chk(v == 0, "R3 no valid after error", v, 0);

        // R7: two-ones pattern
        pat = 3; calib_mode = 1'b1;
        do_reset();
        frames(60);
        chk(align_err_o && !locked_o && slip_o == 11, "R7 error two ones", int'(align_err_o), 1);

        // R9: calibration low before lock
        delay = 5; pat = 0; calib_mode = 1'b0;
        do_reset();
        frames(20);
        chk(slip_o == 0 && !locked_o && !align_err_o, "R9 idle", int'(slip_o), 0);
        calib_mode = 1'b1;
        wait_lock(80);
        chk(locked_o && slip_o == 7, "R9 then lock", int'(slip_o), 7);

        // R8: reset after lock
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(slip_o == 0 && !locked_o && !align_err_o, "R8 clear after lock", int'(slip_o), 0);
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule